// File: doc/BRIEF.md
# Memory Board Select and Write-Protect Control

This block is the control logic of an 8 KB static RAM board that sits on a parallel microcomputer bus. It does not hold the RAM. It decides whether the current bus address falls in the board's window. It picks which of the eight 1 KB pages is addressed and turns on the matching chip enable. It also gates the drivers that put read data on the bus and the RAM write enable.

The window is set by three switches. They hold the one's complement of the board's three top address bits. The board is selected when adding the switch value to bus bits A13–A15 gives all ones. The carry out of the page stage takes part in that sum. The page stage is the sum of bus bits A10–A12 and a fixed low base.

A write-protect latch is set and cleared from the bus and reports its state on an active-low status line. A phantom input, honoured only when a jumper input says so, silences the whole board. This lets another memory overlay the same addresses.

All bus inputs are sampled on the system clock. Every output is combinational from those samples and from the protect latch. Each output therefore reflects the inputs present at the previous rising edge.

Top module: `mboard_ctl`

## Requirements
- R1: The board is selected when the low three bits of (bus A15..A13 + `base_sw_n` + carry) are all ones. The carry is the carry out of (bus A12..A10 + LOW_BASE). `base_sw_n` bit 2 pairs with A15 and bit 0 with A13. With the default LOW_BASE of 0, this means the board is selected exactly when A15..A13 equals the bitwise inverse of `base_sw_n`.
- R2: The page index is (A12..A10 + LOW_BASE) mod 8. When enabled, `page_ce_o` has exactly bit `index` set, and bit i stands for page i.
- R3: `page_ce_o` is nonzero only when the board is selected and either (memory read and data-in strobe are both high) or the memory write strobe is high. Otherwise it is all zeros.
- R4: `dout_en_o` is high exactly when the board is selected, memory read and data-in strobe are both high, and the memory write strobe is low.
- R5: `ram_we_o` is high exactly when the board is selected, the memory write strobe is high and the protect latch is clear. It follows the write strobe for the whole length of the pulse.
- R6: A high `prot_i` at a rising edge sets the protect latch. From the next cycle on, `prot_stat_n_o` is low and writes are blocked.
- R7: A high `unprot_i` at a rising edge clears the latch. When `prot_i` and `unprot_i` are high together, the latch ends up set.
- R8: When `phantom_jmp_i` is high and `phantom_n_i` is low, the board is deselected for every address and switch setting. All page enables, `dout_en_o` and `ram_we_o` are then low. When `phantom_jmp_i` is low, `phantom_n_i` has no effect.
- R9: While `rst` is high and after it, until new inputs are sampled, the latch is clear. All enables are low and `prot_stat_n_o` is high.
- R10: Every enable output reflects the bus inputs present at the previous rising edge of `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_adr_i | input | 6 | Bus address A15..A10 (bit 0 = A10) |
| base_sw_n | input | 3 | Inverted board base, bit 2 pairs with A15 |
| memr_i | input | 1 | Memory read strobe |
| memw_i | input | 1 | Memory write strobe |
| dbin_i | input | 1 | Data-in strobe |
| prot_i | input | 1 | Set write protection |
| unprot_i | input | 1 | Clear write protection |
| phantom_n_i | input | 1 | Phantom request, active low |
| phantom_jmp_i | input | 1 | High when the phantom jumper is fitted |
| page_ce_o | output | 8 | One-hot page chip enables |
| dout_en_o | output | 1 | Read data driver enable |
| ram_we_o | output | 1 | RAM write enable |
| prot_stat_n_o | output | 1 | Protect status, low while protected |

## Verification
On every cycle, the assertions check the properties that tie outputs to inputs seen one edge earlier. The page enables are never more than one-hot, and with no strobe they are all zero. A write enable never coexists with a read driver enable or with a set protect latch. PROT, UNPROT and phantom act on the next cycle as required. The address arithmetic can only be confirmed by the bench's sweeps: the window match for each switch setting, the page index, and the exact enable value for each strobe combination. Those sweeps cover all eight switch settings, all 64 address values, every strobe mix, both protect states and every phantom/jumper pair. Expected outputs are computed by addition in the bench.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

  // Bus control strobes captured on each rising edge
  typedef struct packed {
    logic memr;
    logic memw;
    logic dbin;
    logic phantom_n;
    logic phantom_jmp;
  } bus_ctl_t;

endpackage

// File: rtl/mbc_match.sv
// Window compare by addition plus page index computation
module mbc_match #(
  parameter int PAGE_W   = 3,
  parameter int HI_W     = 3,
  parameter int LOW_BASE = 0
) (
  input  logic [PAGE_W-1:0] adr_lo,
  input  logic [HI_W-1:0]   adr_hi,
  input  logic [HI_W-1:0]   sw_n,
  input  logic              kill,
  output logic              sel,
  output logic [PAGE_W-1:0] page
);
  localparam logic [PAGE_W:0] LOW_V = LOW_BASE[PAGE_W:0];

  logic [PAGE_W:0] lo_sum;
  logic [HI_W-1:0] hi_sum;
  logic [HI_W-1:0] cin_ext;

  always_comb begin
    lo_sum  = {1'b0, adr_lo} + LOW_V;
    cin_ext = {{(HI_W-1){1'b0}}, lo_sum[PAGE_W]};
    hi_sum  = adr_hi + sw_n + cin_ext;
    page    = lo_sum[PAGE_W-1:0];
    sel     = (&hi_sum) & ~kill;
  end
endmodule

// File: rtl/mbc_pagedec.sv
// Enable-gated binary to one-hot page decoder
module mbc_pagedec #(
  parameter int PAGE_W = 3
) (
  input  logic                   en,
  input  logic [PAGE_W-1:0]      page,
  output logic [(1<<PAGE_W)-1:0] ce
);
  localparam int PAGES = 1 << PAGE_W;

  for (genvar g = 0; g < PAGES; g++) begin : g_ce
    assign ce[g] = en && (page == PAGE_W'(g));
  end
endmodule

// File: rtl/mbc_protlatch.sv
// Set-dominant write-protect flag
module mbc_protlatch (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic prot_o
);
  always_ff @(posedge clk) begin
    if (rst)        prot_o <= 1'b0;
    else if (set_i) prot_o <= 1'b1;
    else if (clr_i) prot_o <= 1'b0;
  end
endmodule

// File: rtl/mboard_ctl.sv
module mboard_ctl #(
  parameter int PAGE_W   = 3,
  parameter int HI_W     = 3,
  parameter int LOW_BASE = 0
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [PAGE_W+HI_W-1:0]      bus_adr_i,
  input  logic [HI_W-1:0]             base_sw_n,
  input  logic                        memr_i,
  input  logic                        memw_i,
  input  logic                        dbin_i,
  input  logic                        prot_i,
  input  logic                        unprot_i,
  input  logic                        phantom_n_i,
  input  logic                        phantom_jmp_i,
  output logic [(1<<PAGE_W)-1:0]      page_ce_o,
  output logic                        dout_en_o,
  output logic                        ram_we_o,
  output logic                        prot_stat_n_o
);
  import mbc_pkg::*;

  localparam int ADR_W = PAGE_W + HI_W;

  logic [ADR_W-1:0] adr_q;
  logic [HI_W-1:0]  sw_q;
  bus_ctl_t         ctl_q;
  logic             sel;
  logic [PAGE_W-1:0] page;
  logic             prot;
  logic             rd_cyc;
  logic             dec_en;

  // Input sampling stage
  always_ff @(posedge clk) begin
    if (rst) begin
      adr_q <= '0;
      sw_q  <= '0;
      ctl_q <= '{memr: 1'b0, memw: 1'b0, dbin: 1'b0,
                 phantom_n: 1'b1, phantom_jmp: 1'b0};
    end else begin
      adr_q <= bus_adr_i;
      sw_q  <= base_sw_n;
      ctl_q <= '{memr: memr_i, memw: memw_i, dbin: dbin_i,
                 phantom_n: phantom_n_i, phantom_jmp: phantom_jmp_i};
    end
  end

  mbc_match #(.PAGE_W(PAGE_W), .HI_W(HI_W), .LOW_BASE(LOW_BASE)) u_match (
    .adr_lo (adr_q[PAGE_W-1:0]),
    .adr_hi (adr_q[ADR_W-1:PAGE_W]),
    .sw_n   (sw_q),
    .kill   (ctl_q.phantom_jmp & ~ctl_q.phantom_n),
    .sel    (sel),
    .page   (page)
  );

  mbc_protlatch u_prot (
    .clk    (clk),
    .rst    (rst),
    .set_i  (prot_i),
    .clr_i  (unprot_i),
    .prot_o (prot)
  );

  always_comb begin
    rd_cyc = ctl_q.memr & ctl_q.dbin;
    dec_en = sel & (rd_cyc | ctl_q.memw);
  end

  mbc_pagedec #(.PAGE_W(PAGE_W)) u_dec (
    .en   (dec_en),
    .page (page),
    .ce   (page_ce_o)
  );

  assign dout_en_o     = sel & rd_cyc & ~ctl_q.memw;
  assign ram_we_o      = sel & ctl_q.memw & ~prot;
  assign prot_stat_n_o = ~prot;
endmodule

// File: rtl/mbc_chk.sv
module mbc_chk #(
  parameter int PAGES = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             memr_i,
  input logic             memw_i,
  input logic             prot_i,
  input logic             unprot_i,
  input logic             phantom_n_i,
  input logic             phantom_jmp_i,
  input logic [PAGES-1:0] page_ce_o,
  input logic             dout_en_o,
  input logic             ram_we_o,
  input logic             prot_stat_n_o
);
  // R2
  page_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(page_ce_o));

  // R3
  page_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!memr_i && !memw_i) |=> (page_ce_o == '0));

  // R4
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
    dout_en_o |-> !ram_we_o);

  // R5
  we_unprot_chk: assert property (@(posedge clk) disable iff (rst)
    ram_we_o |-> prot_stat_n_o);

  // R6
  prot_set_chk: assert property (@(posedge clk) disable iff (rst)
    prot_i |=> !prot_stat_n_o);

  // R7
  prot_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (unprot_i && !prot_i) |=> prot_stat_n_o);

  // R8
  phantom_kill_chk: assert property (@(posedge clk) disable iff (rst)
    (phantom_jmp_i && !phantom_n_i) |=>
      (page_ce_o == '0 && !dout_en_o && !ram_we_o));
endmodule

bind mboard_ctl mbc_chk #(.PAGES(1 << PAGE_W)) u_mbc_chk (
  .clk           (clk),
  .rst           (rst),
  .memr_i        (memr_i),
  .memw_i        (memw_i),
  .prot_i        (prot_i),
  .unprot_i      (unprot_i),
  .phantom_n_i   (phantom_n_i),
  .phantom_jmp_i (phantom_jmp_i),
  .page_ce_o     (page_ce_o),
  .dout_en_o     (dout_en_o),
  .ram_we_o      (ram_we_o),
  .prot_stat_n_o (prot_stat_n_o)
);

// File: tb/test_mboard_ctl.sv
`timescale 1ns/1ps
module test_mboard_ctl;
  localparam int LB = 0;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] bus_adr_i = '0;
  logic [2:0] base_sw_n = '0;
  logic       memr_i = 0, memw_i = 0, dbin_i = 0;
  logic       prot_i = 0, unprot_i = 0;
  logic       phantom_n_i = 1, phantom_jmp_i = 0;
  logic [7:0] page_ce_o;
  logic       dout_en_o, ram_we_o, prot_stat_n_o;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mboard_ctl #(.PAGE_W(3), .HI_W(3), .LOW_BASE(LB)) i_mboard_ctl (
    .clk(clk), .rst(rst), .bus_adr_i(bus_adr_i), .base_sw_n(base_sw_n),
    .memr_i(memr_i), .memw_i(memw_i), .dbin_i(dbin_i),
    .prot_i(prot_i), .unprot_i(unprot_i),
    .phantom_n_i(phantom_n_i), .phantom_jmp_i(phantom_jmp_i),
    .page_ce_o(page_ce_o), .dout_en_o(dout_en_o),
    .ram_we_o(ram_we_o), .prot_stat_n_o(prot_stat_n_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    #1;
  endtask

  task automatic pulse(input bit p, input bit u);
    @(negedge clk);
    prot_i = p; unprot_i = u;
    step();
    @(negedge clk);
    prot_i = 0; unprot_i = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    // R9 reset state
    chk("R9 ce", page_ce_o, 0);
    chk("R9 dout", dout_en_o, 0);
    chk("R9 we", ram_we_o, 0);
    chk("R9 stat", prot_stat_n_o, 1);
    @(negedge clk); rst = 0;

    // R6, R7 latch behaviour
    pulse(1, 0); chk("R6 set", prot_stat_n_o, 0);
    pulse(0, 1); chk("R7 clear", prot_stat_n_o, 1);
    pulse(1, 1); chk("R7 both set wins", prot_stat_n_o, 0);
    pulse(0, 0); chk("R6 holds", prot_stat_n_o, 0);

    for (int ps = 0; ps < 2; ps++) begin
      if (ps == 0) pulse(0, 1); else pulse(1, 0);
      for (int ph = 0; ph < 4; ph++) begin
        for (int sw = 0; sw < 8; sw++) begin
          for (int a = 0; a < 64; a++) begin
            for (int s = 0; s < 8; s++) begin
              bit r, w, d, jmp, phn, sel, kill, dec;
              int lo, c, hi, pg;
              r = s[0]; w = s[1]; d = s[2];
              jmp = ph[1]; phn = ph[0];
              @(negedge clk);
              bus_adr_i = 6'(a); base_sw_n = 3'(sw);
              memr_i = r; memw_i = w; dbin_i = d;
              phantom_jmp_i = jmp; phantom_n_i = phn;
              step();
              // R10 sampled one edge after inputs were applied
              lo   = (a & 7) + LB;
              c    = lo >> 3;
              pg   = lo & 7;
              hi   = ((a >> 3) + sw + c) & 7;
              kill = jmp && !phn;
              sel  = (hi == 7) && !kill;
              dec  = sel && ((r && d) || w);
              // R1 R2 R3 R8
              chk("R1/R2/R3/R8 page_ce", page_ce_o, dec ? (1 << pg) : 0);
              // R4
              chk("R4 dout_en", dout_en_o, int'(sel && r && d && !w));
              // R5
              chk("R5 ram_we", ram_we_o, int'(sel && w && (ps == 0)));
              chk("R6 stat", prot_stat_n_o, int'(ps == 0));
            end
          end
        end
      end
    end

    // R5 write enable tracks a multi-cycle write pulse
    pulse(0, 1);
    @(negedge clk);
    bus_adr_i = 6'h2A; base_sw_n = 3'b010; phantom_jmp_i = 0;
    memr_i = 0; dbin_i = 0; memw_i = 1;
    step(); chk("R5 pulse c1", ram_we_o, 1);
    step(); chk("R5 pulse c2", ram_we_o, 1);
    @(negedge clk); memw_i = 0;
    step(); chk("R5 pulse end", ram_we_o, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule